// File: doc/BRIEF.md
# Special Exception Vector Selector

This block sits beside a small CPU's sequencer. At each instruction boundary it decides whether one of three always-enabled special exceptions is taken: a software trap, an undefined opcode, or a nonmaskable interrupt from an external pin. It also decides whether a single maskable request, which arrives with its own vector, may be acknowledged instead. When something is selected, the block issues a one-cycle take pulse with the 16-bit indirect vector address and a source code. The CPU then performs the call.

The two opcode exceptions come straight from the opcode presented at the boundary strobe. The trap opcode is fixed, and the undefined codes form a parameterised set. Neither needs an edge detector or a pending flag. The pin source is synchronised and edge-detected, and it is latched as pending until it is taken. After an opcode exception, a short window counted in instruction boundaries holds off the maskable request. The pin-driven interrupt may still be taken during that window.

Top module: `exc_vector_ctrl`

## Requirements
- R1: After reset, `take` is low, no pin interrupt is pending and no hold-off window is active, so a boundary strobe with a defined opcode and no maskable request yields no take.
- R2: A boundary strobe with opcode 0xF7 produces a take on the next clock with vector 0x2010 and source code 0. No enable input gates it.
- R3: A boundary strobe with an opcode in the configured undefined set (default 0x04, 0x1C, 0x36, 0xEF) produces a take with vector 0x2012 and source code 1. A defined opcode produces no take.
- R4: A rising edge on the pin, once synchronised, latches a pending request. The next boundary strobe takes it with vector 0x203E and source code 2. A pin held high gives exactly one take.
- R5: If the pin is high when reset ends, it raises no request until it has been seen low and then rises again.
- R6: If an opcode exception and a pending pin request meet at one boundary, the opcode exception is taken and the pin request stays pending for the following boundary.
- R7: A pending pin request wins over a maskable request at the same boundary.
- R8: After an opcode exception, the maskable request is not acknowledged at the next INHIBIT_INSNS boundary strobes (default 1). A pin request may still be taken inside that window.
- R9: With nothing special pending and no window active, a maskable request at a boundary is taken with its own vector and source code 3.
- R10: No take occurs without a boundary strobe on the previous clock, and a pending request is held across cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| boundary | input | 1 | One-cycle strobe marking an instruction boundary |
| opcode | input | 8 | Opcode of the instruction at this boundary |
| nmi_pin | input | 1 | Asynchronous nonmaskable interrupt pin, active on a rising edge |
| mreq | input | 1 | Maskable request from the general interrupt controller |
| mreq_vec | input | 16 | Vector address belonging to the maskable request |
| take | output | 1 | One-cycle pulse: an exception or interrupt is taken |
| take_vec | output | 16 | Vector address of the taken source |
| take_src | output | 2 | Source code: 0 trap, 1 undefined opcode, 2 pin, 3 maskable |

## Verification
Every take is registered, so it appears on the clock after the edge that sampled the boundary strobe. The bench raises the strobe at a falling edge and reads `take`, `take_vec` and `take_src` at the next falling edge. A pin edge needs three rising edges (two synchroniser stages, then the pending flag) before a strobe can see it, so the bench waits four clocks after moving the pin before it strobes. The hold-off window is checked over a sequence of strobes rather than clock counts, because the window advances only on strobes.

// File: rtl/excv_pkg.sv
package excv_pkg;
  localparam logic [7:0]  TRAP_OPCODE = 8'hF7;
  localparam logic [15:0] VEC_TRAP    = 16'h2010;
  localparam logic [15:0] VEC_UNDEF   = 16'h2012;
  localparam logic [15:0] VEC_NMI     = 16'h203E;

  typedef enum logic [1:0] {
    SRC_TRAP  = 2'd0,
    SRC_UNDEF = 2'd1,
    SRC_NMI   = 2'd2,
    SRC_MASK  = 2'd3
  } exc_src_e;
endpackage

// File: rtl/excv_undef_decode.sv
module excv_undef_decode #(
  parameter int unsigned          NUM_CODES = 4,
  parameter logic [NUM_CODES*8-1:0] CODES   = {8'h04, 8'h1C, 8'h36, 8'hEF}
) (
  input  logic [7:0] opcode,
  output logic       is_undef
);
  logic [NUM_CODES-1:0] hit;

  generate
    for (genvar g = 0; g < NUM_CODES; g++) begin : g_cmp
      assign hit[g] = (opcode == CODES[g*8 +: 8]);
    end
  endgenerate

  assign is_undef = |hit;
endmodule

// File: rtl/excv_nmi_latch.sv
module excv_nmi_latch #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic clr,
  output logic pending
);
  // Synchroniser and history flop reset to 1, so a pin already high at
  // reset only counts once it has been observed low.
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   hist_q, hist_d;
  logic                   pend_q, pend_d;
  logic                   rise;

  assign rise = sync_q[SYNC_STAGES-1] & ~hist_q;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], pin};
    hist_d = sync_q[SYNC_STAGES-1];
    pend_d = pend_q;
    if (clr)  pend_d = 1'b0;
    if (rise) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      hist_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      hist_q <= hist_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;

  // R4: a latched request persists until it is taken
  a_r4_pending_held: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !clr |=> pend_q);
  // R4: one rise per high phase of the pin
  a_r4_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);
endmodule

// File: rtl/excv_holdoff.sv
module excv_holdoff #(
  parameter int unsigned INHIBIT_INSNS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic load,
  output logic active
);
  localparam int unsigned CW = $clog2(INHIBIT_INSNS + 1);
  localparam logic [CW-1:0] CNT_INIT = CW'(INHIBIT_INSNS);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en = step;

  always_comb begin
    cnt_d = cnt_q;
    if (load)              cnt_d = CNT_INIT;
    else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign active = (cnt_q != '0);

  // R8: the window never outlasts its configured length
  a_r8_window_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_INIT);
  // R10: the window only moves on a boundary strobe
  a_r10_window_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt_q));
endmodule

// File: rtl/exc_vector_ctrl.sv
module exc_vector_ctrl #(
  parameter int unsigned            NUM_UNDEF     = 4,
  parameter logic [NUM_UNDEF*8-1:0] UNDEF_CODES   = {8'h04, 8'h1C, 8'h36, 8'hEF},
  parameter int unsigned            INHIBIT_INSNS = 1,
  parameter int unsigned            SYNC_STAGES   = 2,
  parameter int unsigned            VEC_W         = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             boundary,
  input  logic [7:0]       opcode,
  input  logic             nmi_pin,
  input  logic             mreq,
  input  logic [VEC_W-1:0] mreq_vec,
  output logic             take,
  output logic [VEC_W-1:0] take_vec,
  output logic [1:0]       take_src
);
  import excv_pkg::*;

  logic is_trap, is_undef_raw, is_undef, op_exc;
  logic nmi_pend, nmi_clr, holdoff;
  logic sel_any;
  exc_src_e sel_src;
  logic [VEC_W-1:0] sel_vec;

  logic             take_q, take_d;
  logic [VEC_W-1:0] vec_q, vec_d;
  exc_src_e         src_q, src_d;

  excv_undef_decode #(.NUM_CODES(NUM_UNDEF), .CODES(UNDEF_CODES)) i_undef (
    .opcode  (opcode),
    .is_undef(is_undef_raw)
  );

  excv_nmi_latch #(.SYNC_STAGES(SYNC_STAGES)) i_nmi (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin    (nmi_pin),
    .clr    (nmi_clr),
    .pending(nmi_pend)
  );

  excv_holdoff #(.INHIBIT_INSNS(INHIBIT_INSNS)) i_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (boundary),
    .load  (op_exc),
    .active(holdoff)
  );

  assign is_trap  = (opcode == TRAP_OPCODE);
  assign is_undef = is_undef_raw & ~is_trap;
  assign op_exc   = boundary & (is_trap | is_undef);

  // Priority: opcode exceptions, then pin, then maskable outside the window.
  always_comb begin
    sel_any = 1'b0;
    sel_src = SRC_TRAP;
    sel_vec = VEC_W'(VEC_TRAP);
    if (boundary) begin
      if (is_trap) begin
        sel_any = 1'b1;
      end else if (is_undef) begin
        sel_any = 1'b1;
        sel_src = SRC_UNDEF;
        sel_vec = VEC_W'(VEC_UNDEF);
      end else if (nmi_pend) begin
        sel_any = 1'b1;
        sel_src = SRC_NMI;
        sel_vec = VEC_W'(VEC_NMI);
      end else if (mreq && !holdoff) begin
        sel_any = 1'b1;
        sel_src = SRC_MASK;
        sel_vec = mreq_vec;
      end
    end
  end

  assign nmi_clr = sel_any & (sel_src == SRC_NMI);

  always_comb begin
    take_d = sel_any;
    vec_d  = sel_any ? sel_vec : vec_q;
    src_d  = sel_any ? sel_src : src_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q <= 1'b0;
      vec_q  <= '0;
      src_q  <= SRC_TRAP;
    end else begin
      take_q <= take_d;
      vec_q  <= vec_d;
      src_q  <= src_d;
    end
  end

  assign take     = take_q;
  assign take_vec = vec_q;
  assign take_src = src_q;

  // R10: every take follows a boundary strobe
  a_r10_take_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));
  // R2: trap opcode is always taken with its vector
  a_r2_trap_taken: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && opcode == TRAP_OPCODE |=> take && take_vec == VEC_W'(VEC_TRAP));
  // R6: pin request survives a coinciding opcode exception
  a_r6_nmi_deferred: assert property (@(posedge clk) disable iff (!rst_n)
    op_exc && nmi_pend |=> nmi_pend);
  // R8: no maskable acknowledge while the window is open
  a_r8_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && holdoff |=> !(take && take_src == 2'd3));
endmodule

// File: tb/test_exc_vector_ctrl.sv
module test_exc_vector_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        boundary;
  logic [7:0]  opcode;
  logic        nmi_pin;
  logic        mreq;
  logic [15:0] mreq_vec;
  logic        take;
  logic [15:0] take_vec;
  logic [1:0]  take_src;

  int checks = 0;
  int fails  = 0;

  localparam logic [7:0] NOP = 8'h05;

  always #4 clk = ~clk;

  exc_vector_ctrl i_exc_vector_ctrl (
    .clk(clk), .rst_n(rst_n), .boundary(boundary), .opcode(opcode),
    .nmi_pin(nmi_pin), .mreq(mreq), .mreq_vec(mreq_vec),
    .take(take), .take_vec(take_vec), .take_src(take_src)
  );

  task automatic check(input string req, input logic et, input logic [15:0] ev,
                       input logic [1:0] es);
    checks++;
    if (take !== et || (et && (take_vec !== ev || take_src !== es))) begin
      fails++;
      $display("FAIL %s: take=%0b vec=%h src=%0d expected take=%0b vec=%h src=%0d",
               req, take, take_vec, take_src, et, ev, es);
    end
  endtask

  // Strobe a boundary at a falling edge, read the result one clock later.
  task automatic strobe(input logic [7:0] op, input string req, input logic et,
                        input logic [15:0] ev, input logic [1:0] es);
    @(negedge clk);
    boundary = 1'b1;
    opcode   = op;
    @(negedge clk);
    boundary = 1'b0;
    opcode   = NOP;
    check(req, et, ev, es);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 1'b0; boundary = 1'b0; opcode = NOP; nmi_pin = pin;
    mreq = 1'b0; mreq_vec = 16'h2030;
    idle(2);
    rst_n = 1'b1;
    idle(1);
  endtask

  task automatic t_reset;
    do_reset(1'b0);
    checks++;
    if (take !== 1'b0) begin fails++; $display("FAIL R1: take=%0b expected 0", take); end
    strobe(NOP, "R1", 1'b0, 16'h0, 2'd0);
  endtask

  task automatic t_trap;
    strobe(8'hF7, "R2", 1'b1, 16'h2010, 2'd0);
    idle(2);
    check("R10", 1'b0, 16'h0, 2'd0);
  endtask

  task automatic t_undef;
    strobe(8'h04, "R3", 1'b1, 16'h2012, 2'd1);
    strobe(8'hEF, "R3", 1'b1, 16'h2012, 2'd1);
    strobe(8'h1C, "R3", 1'b1, 16'h2012, 2'd1);
    strobe(8'h36, "R3", 1'b1, 16'h2012, 2'd1);
    strobe(8'h37, "R3", 1'b0, 16'h0, 2'd0);
  endtask

  task automatic t_nmi;
    nmi_pin = 1'b1;
    idle(8);
    check("R10", 1'b0, 16'h0, 2'd0);
    strobe(NOP, "R4", 1'b1, 16'h203E, 2'd2);
    idle(4);
    strobe(NOP, "R4", 1'b0, 16'h0, 2'd0);
    nmi_pin = 1'b0;
    idle(4);
  endtask

  task automatic t_high_at_reset;
    do_reset(1'b1);
    idle(6);
    strobe(NOP, "R5", 1'b0, 16'h0, 2'd0);
    nmi_pin = 1'b0;
    idle(4);
    nmi_pin = 1'b1;
    idle(4);
    strobe(NOP, "R5", 1'b1, 16'h203E, 2'd2);
    nmi_pin = 1'b0;
    idle(4);
  endtask

  task automatic t_coincide;
    nmi_pin = 1'b1;
    idle(4);
    strobe(8'hF7, "R6", 1'b1, 16'h2010, 2'd0);
    strobe(NOP, "R6", 1'b1, 16'h203E, 2'd2);
    strobe(NOP, "R6", 1'b0, 16'h0, 2'd0);
    nmi_pin = 1'b0;
    idle(4);
  endtask

  task automatic t_nmi_vs_mask;
    mreq = 1'b1;
    nmi_pin = 1'b1;
    idle(4);
    strobe(NOP, "R7", 1'b1, 16'h203E, 2'd2);
    strobe(NOP, "R9", 1'b1, 16'h2030, 2'd3);
    mreq = 1'b0;
    nmi_pin = 1'b0;
    idle(4);
  endtask

  task automatic t_window;
    mreq = 1'b1;
    mreq_vec = 16'h2034;
    strobe(8'h36, "R8", 1'b1, 16'h2012, 2'd1);
    strobe(NOP, "R8", 1'b0, 16'h0, 2'd0);
    strobe(NOP, "R8", 1'b1, 16'h2034, 2'd3);
    // pin request still allowed inside the window
    strobe(8'hF7, "R8", 1'b1, 16'h2010, 2'd0);
    nmi_pin = 1'b1;
    idle(4);
    strobe(NOP, "R8", 1'b1, 16'h203E, 2'd2);
    strobe(NOP, "R9", 1'b1, 16'h2034, 2'd3);
    mreq = 1'b0;
    nmi_pin = 1'b0;
    idle(4);
  endtask

  initial begin
    t_reset();
    t_trap();
    t_undef();
    t_nmi();
    t_high_at_reset();
    t_coincide();
    t_nmi_vs_mask();
    t_window();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule